// File: doc/BRIEF.md
# Branch Entry Prediction Decoder

This block takes one entry that the lookup storage has hit, together with the start PC of the fetch block, and turns the entry into prediction outputs. An entry holds two branch slots and a partial end address. The decoder rebuilds each slot's full target from the low bits stored in the slot. It takes the PC high bits above those low bits and increments, decrements or keeps them, according to the slot's 2-bit target status. It rebuilds the fall-through (end) address of the block from a 4-bit partial address and a carry bit. It also reports per-slot valid and offset, classifies the second slot as a conditional branch or an unconditional jump with call/return/indirect flags, and forces taken-mask bits from the entry's always-taken bits.

The decoded result is available combinationally in the same cycle as the hit (the stage-2 view). A registered copy of the hit, slot valids, targets and fall-through appears one cycle later (the stage-3 view). Every output is qualified by the hit flag and the slot valid bits. A miss yields a fall-through of start PC + 32 and zeros everywhere else.

Top module: `brent_decode`

## Requirements
- R1: Slot-0 target = {PC[PC_W-1:13] adjusted, lo0[11:0], 1'b0}. Status code 1 adds one to the high part, code 2 subtracts one, and codes 0 and 3 keep it. The arithmetic wraps modulo the high-part width.
- R2: Slot-1 target = {PC[PC_W-1:21] adjusted, lo1[19:0], 1'b0}, using the same status codes and the same wrap as R1.
- R3: On a hit, fall-through = {PC[PC_W-1:5] + carry, part[3:0], 1'b0}. Offsets and the partial end are in 2-byte units.
- R4: On a miss, p_fall = start_pc + 32. Every other stage-2 output is zero, whatever the entry fields hold.
- R5: A slot whose valid bit is 0 reports zero for its valid, offset, target, conditional and taken-mask outputs. On a hit with the slot valid, its offset equals the stored 4-bit offset.
- R6: p_tkmask[0] = hit & valid0 & always_tk[0]. p_tkmask[1] = hit & valid1 & share1 & always_tk[1].
- R7: Slot 1 with share1=1 is conditional (p_cond[1]=1, p_jmp=0, type flags 0). With share1=0 it is a jump (p_jmp=1), and p_call/p_ret/p_jalr follow is_call/is_ret/is_jalr. Slot 0 is always conditional when valid.
- R8: r_hit, r_vld, r_tgt0, r_tgt1 and r_fall equal the stage-2 values of the previous clock. They are zero after reset, which is active-low and asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pc | input | PC_W | Start PC of the fetch block |
| hit | input | 1 | Entry hit flag |
| s0_valid | input | 1 | Slot 0 valid |
| s0_ofs | input | 4 | Slot 0 offset, 2-byte units |
| s0_lo | input | 12 | Slot 0 stored target low bits |
| s0_stat | input | 2 | Slot 0 target status |
| s1_valid | input | 1 | Slot 1 valid |
| s1_ofs | input | 4 | Slot 1 offset, 2-byte units |
| s1_lo | input | 20 | Slot 1 stored target low bits |
| s1_stat | input | 2 | Slot 1 target status |
| s1_share | input | 1 | Slot 1 holds a conditional branch |
| end_part | input | 4 | Partial end address |
| end_carry | input | 1 | Carry into end address high part |
| is_call | input | 1 | Jump is a call |
| is_ret | input | 1 | Jump is a return |
| is_jalr | input | 1 | Jump is register-indirect |
| always_tk | input | 2 | Always-taken bits per slot |
| p_vld | output | 2 | Qualified slot valids |
| p_ofs0 | output | 4 | Qualified slot 0 offset |
| p_ofs1 | output | 4 | Qualified slot 1 offset |
| p_tgt0 | output | PC_W | Slot 0 target |
| p_tgt1 | output | PC_W | Slot 1 target |
| p_fall | output | PC_W | Fall-through address |
| p_cond | output | 2 | Slot is a conditional branch |
| p_jmp | output | 1 | Slot 1 is an unconditional jump |
| p_call | output | 1 | Jump is a call |
| p_ret | output | 1 | Jump is a return |
| p_jalr | output | 1 | Jump is indirect |
| p_tkmask | output | 2 | Forced taken mask |
| r_hit | output | 1 | Registered hit |
| r_vld | output | 2 | Registered slot valids |
| r_tgt0 | output | PC_W | Registered slot 0 target |
| r_tgt1 | output | PC_W | Registered slot 1 target |
| r_fall | output | PC_W | Registered fall-through |

## Verification
The hardest cases to reach are the wrap-arounds of the high-part arithmetic. A decrement from a zero high part must produce all ones. An increment or carry from an all-ones high part must produce zero. Both arise only for start PCs at the extremes of the address space. The vector table therefore places PCs at 0x4000, where slot 1's 19-bit high part is zero, and at the top of the 40-bit space. Hand-computed targets and fall-throughs are checked against these PCs under each status code.

// File: rtl/brent_pkg.sv
package brent_pkg;
  // Target status codes: how the PC high part is moved before joining the low bits
  typedef enum logic [1:0] {
    TST_KEEP = 2'd0,
    TST_INC  = 2'd1,
    TST_DEC  = 2'd2,
    TST_RSVD = 2'd3
  } tstat_e;

  localparam int NSLOT  = 2;
  localparam int OFS_W  = 4;
  localparam int STAT_W = 2;
endpackage

// File: rtl/brent_tgt_rebuild.sv
module brent_tgt_rebuild #(
  parameter int PC_W = 40,
  parameter int LO_W = 12,
  localparam int HI_W = PC_W - LO_W - 1
) (
  input  logic [HI_W-1:0] pc_hi,
  input  logic [1:0]      stat,
  input  logic [LO_W-1:0] lo,
  output logic [PC_W-1:0] tgt,
  output logic            adj_inc,
  output logic            adj_dec
);
  import brent_pkg::*;

  function automatic logic [HI_W-1:0] move_hi(input logic [HI_W-1:0] h,
                                               input logic [1:0] s);
    case (tstat_e'(s))
      TST_INC: move_hi = h + HI_W'(1);
      TST_DEC: move_hi = h - HI_W'(1);
      default: move_hi = h;
    endcase
  endfunction

  assign adj_inc = (stat == TST_INC);
  assign adj_dec = (stat == TST_DEC);
  assign tgt     = {move_hi(pc_hi, stat), lo, 1'b0};
endmodule

// File: rtl/brent_end_rebuild.sv
module brent_end_rebuild #(
  parameter int PC_W  = 40,
  parameter int BLK_W = 5,
  localparam int PART_W = BLK_W - 1,
  localparam int HI_W   = PC_W - BLK_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic              hit,
  input  logic [PART_W-1:0] part,
  input  logic              carry,
  output logic [PC_W-1:0]   fall
);
  localparam logic [PC_W-1:0] BLK_BYTES = PC_W'(1) << BLK_W;

  function automatic logic [PC_W-1:0] join_end(input logic [PC_W-1:0] p,
                                               input logic [PART_W-1:0] pt,
                                               input logic c);
    logic [HI_W-1:0] h;
    h = p[PC_W-1:BLK_W] + HI_W'(c);
    join_end = {h, pt, 1'b0};
  endfunction

  assign fall = hit ? join_end(pc, part, carry) : (pc + BLK_BYTES);
endmodule

// File: rtl/brent_out_reg.sv
module brent_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/brent_decode.sv
module brent_decode #(
  parameter int PC_W  = 40,
  parameter int BR_LO = 12,
  parameter int TL_LO = 20,
  parameter int BLK_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  start_pc,
  input  logic             hit,
  input  logic             s0_valid,
  input  logic [3:0]       s0_ofs,
  input  logic [BR_LO-1:0] s0_lo,
  input  logic [1:0]       s0_stat,
  input  logic             s1_valid,
  input  logic [3:0]       s1_ofs,
  input  logic [TL_LO-1:0] s1_lo,
  input  logic [1:0]       s1_stat,
  input  logic             s1_share,
  input  logic [BLK_W-2:0] end_part,
  input  logic             end_carry,
  input  logic             is_call,
  input  logic             is_ret,
  input  logic             is_jalr,
  input  logic [1:0]       always_tk,
  output logic [1:0]       p_vld,
  output logic [3:0]       p_ofs0,
  output logic [3:0]       p_ofs1,
  output logic [PC_W-1:0]  p_tgt0,
  output logic [PC_W-1:0]  p_tgt1,
  output logic [PC_W-1:0]  p_fall,
  output logic [1:0]       p_cond,
  output logic             p_jmp,
  output logic             p_call,
  output logic             p_ret,
  output logic             p_jalr,
  output logic [1:0]       p_tkmask,
  output logic             r_hit,
  output logic [1:0]       r_vld,
  output logic [PC_W-1:0]  r_tgt0,
  output logic [PC_W-1:0]  r_tgt1,
  output logic [PC_W-1:0]  r_fall
);
  import brent_pkg::*;

  localparam int REG_W = 1 + NSLOT + 3 * PC_W;

  // raw per-slot values gathered into arrays for the qualification loop
  logic [PC_W-1:0]  raw_tgt [NSLOT];
  logic [OFS_W-1:0] raw_ofs [NSLOT];
  logic [NSLOT-1:0] raw_vld;
  logic [NSLOT-1:0] slot_is_cond;
  logic [PC_W-1:0]  q_tgt   [NSLOT];
  logic [OFS_W-1:0] q_ofs   [NSLOT];
  logic [NSLOT-1:0] inc_evt, dec_evt;
  logic             jump_live;

  brent_tgt_rebuild #(.PC_W(PC_W), .LO_W(BR_LO)) u_tgt0 (
    .pc_hi   (start_pc[PC_W-1:BR_LO+1]),
    .stat    (s0_stat),
    .lo      (s0_lo),
    .tgt     (raw_tgt[0]),
    .adj_inc (inc_evt[0]),
    .adj_dec (dec_evt[0])
  );

  brent_tgt_rebuild #(.PC_W(PC_W), .LO_W(TL_LO)) u_tgt1 (
    .pc_hi   (start_pc[PC_W-1:TL_LO+1]),
    .stat    (s1_stat),
    .lo      (s1_lo),
    .tgt     (raw_tgt[1]),
    .adj_inc (inc_evt[1]),
    .adj_dec (dec_evt[1])
  );

  brent_end_rebuild #(.PC_W(PC_W), .BLK_W(BLK_W)) u_end (
    .pc    (start_pc),
    .hit   (hit),
    .part  (end_part),
    .carry (end_carry),
    .fall  (p_fall)
  );

  assign raw_ofs[0]      = s0_ofs;
  assign raw_ofs[1]      = s1_ofs;
  assign raw_vld         = {s1_valid, s0_valid};
  assign slot_is_cond[0] = 1'b1;
  assign slot_is_cond[1] = s1_share;

  genvar gs;
  generate
    for (gs = 0; gs < NSLOT; gs++) begin : g_slot
      logic live;
      assign live           = hit & raw_vld[gs];
      assign p_vld[gs]      = live;
      assign q_tgt[gs]      = live ? raw_tgt[gs] : '0;
      assign q_ofs[gs]      = live ? raw_ofs[gs] : '0;
      assign p_cond[gs]     = live & slot_is_cond[gs];
      assign p_tkmask[gs]   = live & slot_is_cond[gs] & always_tk[gs];
    end
  endgenerate

  assign p_tgt0    = q_tgt[0];
  assign p_tgt1    = q_tgt[1];
  assign p_ofs0    = q_ofs[0];
  assign p_ofs1    = q_ofs[1];
  assign jump_live = p_vld[1] & ~s1_share;
  assign p_jmp     = jump_live;
  assign p_call    = jump_live & is_call;
  assign p_ret     = jump_live & is_ret;
  assign p_jalr    = jump_live & is_jalr;

  // stage-3 copy
  logic [REG_W-1:0] st3_d, st3_q;
  assign st3_d = {hit, p_vld, p_tgt0, p_tgt1, p_fall};

  brent_out_reg #(.W(REG_W)) u_st3 (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (st3_d),
    .q     (st3_q)
  );

  assign {r_hit, r_vld, r_tgt0, r_tgt1, r_fall} = st3_q;
endmodule

// File: rtl/brent_decode_chk.sv
module brent_decode_chk #(
  parameter int PC_W = 40
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hit,
  input logic [PC_W-1:0] start_pc,
  input logic [1:0]      p_vld,
  input logic [1:0]      p_cond,
  input logic [1:0]      p_tkmask,
  input logic            p_jmp,
  input logic            p_call,
  input logic            p_ret,
  input logic            p_jalr,
  input logic [PC_W-1:0] p_tgt0,
  input logic [PC_W-1:0] p_fall,
  input logic            r_hit,
  input logic [PC_W-1:0] r_tgt0,
  input logic [PC_W-1:0] r_fall
);
  // R4
  miss_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (p_fall == start_pc + PC_W'(32)));
  // R4
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (p_vld == 2'b00 && p_tkmask == 2'b00 && !p_jmp));
  // R6
  tkmask_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_tkmask & ~p_cond) == 2'b00);
  // R7
  jump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    p_jmp |-> !p_cond[1]);
  // R7
  flags_need_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_call || p_ret || p_jalr) |-> p_jmp);
  // R8
  stage3_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (r_hit == $past(hit)));
  // R8
  stage3_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (r_fall == $past(p_fall) && r_tgt0 == $past(p_tgt0)));
endmodule

bind brent_decode brent_decode_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .start_pc(start_pc),
  .p_vld(p_vld), .p_cond(p_cond), .p_tkmask(p_tkmask), .p_jmp(p_jmp),
  .p_call(p_call), .p_ret(p_ret), .p_jalr(p_jalr), .p_tgt0(p_tgt0),
  .p_fall(p_fall), .r_hit(r_hit), .r_tgt0(r_tgt0), .r_fall(r_fall)
);

// File: tb/sim_brent_decode.sv
`timescale 1ns/1ps
module sim_brent_decode;
  localparam int PC_W = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] start_pc = '0;
  logic            hit = 1'b0;
  logic            s0_valid = 1'b0, s1_valid = 1'b0, s1_share = 1'b0;
  logic [3:0]      s0_ofs = '0, s1_ofs = '0, end_part = '0;
  logic [11:0]     s0_lo = '0;
  logic [19:0]     s1_lo = '0;
  logic [1:0]      s0_stat = '0, s1_stat = '0, always_tk = '0;
  logic            end_carry = 1'b0, is_call = 1'b0, is_ret = 1'b0, is_jalr = 1'b0;
  logic [1:0]      p_vld, p_cond, p_tkmask, r_vld;
  logic [3:0]      p_ofs0, p_ofs1;
  logic [PC_W-1:0] p_tgt0, p_tgt1, p_fall, r_tgt0, r_tgt1, r_fall;
  logic            p_jmp, p_call, p_ret, p_jalr, r_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brent_decode #(.PC_W(PC_W)) u0 (
    .clk, .rst_n, .start_pc, .hit, .s0_valid, .s0_ofs, .s0_lo, .s0_stat,
    .s1_valid, .s1_ofs, .s1_lo, .s1_stat, .s1_share, .end_part, .end_carry,
    .is_call, .is_ret, .is_jalr, .always_tk, .p_vld, .p_ofs0, .p_ofs1,
    .p_tgt0, .p_tgt1, .p_fall, .p_cond, .p_jmp, .p_call, .p_ret, .p_jalr,
    .p_tkmask, .r_hit, .r_vld, .r_tgt0, .r_tgt1, .r_fall
  );

  typedef struct packed {
    logic [39:0] pc;
    logic [1:0]  st0;
    logic [11:0] lo0;
    logic [1:0]  st1;
    logic [19:0] lo1;
    logic [3:0]  part;
    logic        cy;
    logic [39:0] e_t0;
    logic [39:0] e_t1;
    logic [39:0] e_fall;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{40'h00_0000_4000, 2'd1, 12'h123, 2'd0, 20'h00010, 4'h5, 1'b0,
      40'h00_0000_6246, 40'h00_0000_0020, 40'h00_0000_400A},
    '{40'h00_0000_4000, 2'd2, 12'h123, 2'd2, 20'h00010, 4'hF, 1'b1,
      40'h00_0000_2246, 40'hFF_FFE0_0020, 40'h00_0000_403E},
    '{40'h12_3456_789A, 2'd3, 12'hFFF, 2'd1, 20'hABCDE, 4'h3, 1'b0,
      40'h12_3456_7FFE, 40'h12_3475_79BC, 40'h12_3456_7886},
    '{40'hFF_FFFF_FFFE, 2'd1, 12'h001, 2'd1, 20'h00000, 4'h0, 1'b1,
      40'h00_0000_0002, 40'h00_0000_0000, 40'h00_0000_0000}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic full_entry();
    hit = 1'b1; s0_valid = 1'b1; s1_valid = 1'b1; s1_share = 1'b1;
    s0_ofs = 4'h2; s1_ofs = 4'h9; always_tk = 2'b00;
    is_call = 1'b0; is_ret = 1'b0; is_jalr = 1'b0;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state of the stage-3 copy
    chk("R8", "r_hit reset", 64'(r_hit), 64'd0);
    chk("R8", "r_fall reset", 64'(r_fall), 64'd0);
    chk("R8", "r_vld reset", 64'(r_vld), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: vector table
    for (int i = 0; i < 4; i++) begin
      full_entry();
      start_pc = VEC[i].pc; s0_stat = VEC[i].st0; s0_lo = VEC[i].lo0;
      s1_stat = VEC[i].st1; s1_lo = VEC[i].lo1;
      end_part = VEC[i].part; end_carry = VEC[i].cy;
      #1;
      chk("R1", "slot0 target", 64'(p_tgt0), 64'(VEC[i].e_t0));
      chk("R2", "slot1 target", 64'(p_tgt1), 64'(VEC[i].e_t1));
      chk("R3", "fall-through", 64'(p_fall), 64'(VEC[i].e_fall));
      @(posedge clk); #1;
      chk("R8", "r_tgt1 copy", 64'(r_tgt1), 64'(VEC[i].e_t1));
      chk("R8", "r_fall copy", 64'(r_fall), 64'(VEC[i].e_fall));
      chk("R8", "r_hit copy", 64'(r_hit), 64'd1);
      @(negedge clk);
    end

    // R5: offsets pass through on a hit with both slots valid
    full_entry(); #1;
    chk("R5", "ofs0", 64'(p_ofs0), 64'h2);
    chk("R5", "ofs1", 64'(p_ofs1), 64'h9);

    // R4: miss with entry fields still driven
    @(negedge clk);
    full_entry(); hit = 1'b0; always_tk = 2'b11; s1_share = 1'b0; is_call = 1'b1;
    start_pc = 40'h00_0000_4000; #1;
    chk("R4", "miss fall", 64'(p_fall), 64'h4020);
    chk("R4", "miss tgt0", 64'(p_tgt0), 64'd0);
    chk("R4", "miss vld", 64'(p_vld), 64'd0);
    chk("R4", "miss tkmask", 64'(p_tkmask), 64'd0);
    chk("R4", "miss call", 64'(p_call), 64'd0);
    @(posedge clk); #1;
    chk("R8", "r_hit after miss", 64'(r_hit), 64'd0);

    // R5: slot 0 invalid
    @(negedge clk);
    full_entry(); s0_valid = 1'b0; always_tk = 2'b11; #1;
    chk("R5", "slot0 vld", 64'(p_vld), 64'b10);
    chk("R5", "slot0 tgt", 64'(p_tgt0), 64'd0);
    chk("R5", "slot0 ofs", 64'(p_ofs0), 64'd0);
    chk("R6", "tkmask slot0 invalid", 64'(p_tkmask), 64'b10);

    // R6 R7: slot 1 as a jump ignores its always-taken bit
    @(negedge clk);
    full_entry(); s1_share = 1'b0; always_tk = 2'b11;
    is_call = 1'b1; is_ret = 1'b0; is_jalr = 1'b1; #1;
    chk("R6", "tkmask jump slot", 64'(p_tkmask), 64'b01);
    chk("R7", "jmp", 64'(p_jmp), 64'd1);
    chk("R7", "cond", 64'(p_cond), 64'b01);
    chk("R7", "flags", 64'({p_call, p_ret, p_jalr}), 64'b101);

    // R7: slot 1 conditional suppresses type flags
    @(negedge clk);
    full_entry(); s1_share = 1'b1; is_ret = 1'b1; always_tk = 2'b10; #1;
    chk("R7", "cond slot1", 64'(p_cond), 64'b11);
    chk("R7", "no jump", 64'({p_jmp, p_ret}), 64'd0);
    chk("R6", "tkmask slot1", 64'(p_tkmask), 64'b10);

    // R5: slot 1 invalid hides its target and offset
    @(negedge clk);
    full_entry(); s1_valid = 1'b0; #1;
    chk("R5", "slot1 tgt", 64'(p_tgt1), 64'd0);
    chk("R5", "slot1 ofs", 64'(p_ofs1), 64'd0);

    // R8: asynchronous reset clears the copy
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R8", "async reset r_vld", 64'(r_vld), 64'd0);
    chk("R8", "async reset r_tgt0", 64'(r_tgt0), 64'd0);
    finish_run();
  end
endmodule